// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage of one pin in a small programmable logic device. Eight product terms arrive from the AND array. Two mode bits shared by all cells select one of three personalities: a clocked cell, a combinatorial cell whose output enable comes from a product term, or an always-driven combinatorial cell. Two bits per cell set the output polarity and choose between output and input use. The cell drives a pin, modelled as a data value plus a drive enable, and returns a feedback level to the array.

Two parameters fix where the cell sits in the row of cells. An outer cell lends its pin-feedback path to a shared pin when in complex mode. A centre cell can never become an input in simple mode. In simple mode each cell's feedback comes from the neighbouring pin, not from its own pin. The register clears to 0 on reset. A synchronous preload lets a test force the register to any value.

Top module: `pld_out_cell`

## Requirements
- R1: The mode is decoded from {cfg_sync, cfg_arch}: 01 registered, 11 complex, 10 simple. The unused code 00 turns the driver off (pin_oe=0) and gives no feedback (fb_live=0).
- R2: Polarity: with cfg_pol=1 the pin level equals the OR of the active logic terms. With cfg_pol=0 the pin level is its inverse.
- R3: In registered mode with cfg_io=0, the OR of all eight terms (pterm[7:0]), after the polarity rule, is captured on each rising clk edge and appears on pin_out after that edge. pin_oe equals the inverse of the active-low shared enable gl_oe_n.
- R4: In registered mode with cfg_io=1, and in complex mode, pterm[6:0] form the logic and pterm[7] alone drives pin_oe. pterm[7] has no effect on the pin level.
- R5: A cell built with IS_OUTER=1 gives no feedback in complex mode (fb_live=0, fb_out=0).
- R6: In simple mode the pin is driven at all times from all eight terms. cfg_io=1 turns the driver off, except in a cell built with IS_CENTRE=1, which stays an output.
- R7: In simple mode fb_out equals neigh_pin. A centre cell gives no feedback in simple mode.
- R8: While rst_n is low the register holds 0. The pin of a registered output then reads 1 whatever cfg_pol is.
- R9: With preload_en high, the next rising edge loads preload_val into the register in any mode, and this overrides the term data. The registered pin then reads the inverse of preload_val.
- R10: Outside the registered-output configuration the register keeps its value across clock edges unless it is preloaded.
- R11: For a registered output, fb_out is the registered pin level even when the driver is off. For a combinatorial cell, fb_out is pin_out while the pin is driven and pin_in while it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| pterm | input | 8 | Product terms from the AND array |
| gl_oe_n | input | 1 | Shared output enable for registered outputs, active low |
| cfg_sync | input | 1 | Global mode bit, high for complex or simple |
| cfg_arch | input | 1 | Global mode bit, high for registered or complex |
| cfg_pol | input | 1 | Per-cell polarity, 1 = active high |
| cfg_io | input | 1 | Per-cell I/O select |
| preload_en | input | 1 | Synchronous register force |
| preload_val | input | 1 | Value forced into the register |
| pin_in | input | 1 | External level at the pin when not driven |
| neigh_pin | input | 1 | Level at the adjacent cell's pin |
| pin_out | output | 1 | Pin level while driven (0 when not driven) |
| pin_oe | output | 1 | Pin drive enable, 0 = high impedance |
| fb_out | output | 1 | Feedback level to the array |
| fb_live | output | 1 | Feedback path present |

## Verification
Preload and normal capture can fall on the same clock edge. The bench provokes this by holding preload_en high while the product terms call for the opposite register value. It then judges the edge by the pin: pin_out must show the inverse of preload_val, not the term-derived level. The second collision is a change of configuration while clocks keep running: the register must keep its value. This is seen once the cell returns to registered output with no edge in between.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;

  // Encoding is {cfg_sync, cfg_arch}
  typedef enum logic [1:0] {
    MODE_RESV   = 2'b00,
    MODE_REG    = 2'b01,
    MODE_SIMPLE = 2'b10,
    MODE_CPLX   = 2'b11
  } cell_mode_e;

  function automatic cell_mode_e decode_mode(input logic sync_bit, input logic arch_bit);
    return cell_mode_e'({sync_bit, arch_bit});
  endfunction

  // Active-high polarity passes the sum through, active-low inverts it
  function automatic logic polarize(input logic sum, input logic pol);
    return pol ? sum : ~sum;
  endfunction

endpackage

// File: rtl/pld_term_sum.sv
module pld_term_sum #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] pterm,
  output logic               sum_all,
  output logic               sum_logic,
  output logic               oe_term
);
  localparam int LAST = N_TERMS - 1;

  logic [N_TERMS-1:0] chain;

  assign chain[0] = pterm[0];
  for (genvar i = 1; i < N_TERMS; i++) begin : g_or
    assign chain[i] = chain[i-1] | pterm[i];
  end

  assign sum_all   = chain[LAST];
  assign sum_logic = chain[LAST-1];
  assign oe_term   = pterm[LAST];
endmodule

// File: rtl/pld_state_reg.sv
module pld_state_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic d,
  input  logic preload_en,
  input  logic preload_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else if (load_en)    q <= d;
  end

  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> q == $past(preload_val)); // R9
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !preload_en) |=> q == $past(d)); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !preload_en) |=> $stable(q)); // R10
endmodule

// File: rtl/pld_fb_route.sv
module pld_fb_route
  import pld_cell_pkg::*;
#(
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTRE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cell_mode_e mode,
  input  logic       reg_out_cfg,
  input  logic       reg_level,
  input  logic       pin_oe,
  input  logic       pin_out,
  input  logic       pin_in,
  input  logic       neigh_pin,
  output logic       fb_out,
  output logic       fb_live
);
  logic pin_level;
  assign pin_level = pin_oe ? pin_out : pin_in;

  always_comb begin
    fb_out  = 1'b0;
    fb_live = 1'b0;
    unique case (mode)
      MODE_REG: begin
        fb_live = 1'b1;
        fb_out  = reg_out_cfg ? reg_level : pin_level;
      end
      MODE_CPLX: begin
        fb_live = !IS_OUTER;
        fb_out  = IS_OUTER ? 1'b0 : pin_level;
      end
      MODE_SIMPLE: begin
        fb_live = !IS_CENTRE;
        fb_out  = IS_CENTRE ? 1'b0 : neigh_pin;
      end
      default: begin
        fb_out  = 1'b0;
        fb_live = 1'b0;
      end
    endcase
  end

  AST_OUTER_NO_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_OUTER && mode == MODE_CPLX) |-> (!fb_live && !fb_out)); // R5
  AST_NEIGH_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_CENTRE && mode == MODE_SIMPLE) |-> (fb_out == neigh_pin)); // R7
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int N_TERMS   = 8,
  parameter bit IS_OUTER  = 1'b0,
  parameter bit IS_CENTRE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] pterm,
  input  logic               gl_oe_n,
  input  logic               cfg_sync,
  input  logic               cfg_arch,
  input  logic               cfg_pol,
  input  logic               cfg_io,
  input  logic               preload_en,
  input  logic               preload_val,
  input  logic               pin_in,
  input  logic               neigh_pin,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb_out,
  output logic               fb_live
);
  cell_mode_e mode;
  logic sum_all, sum_logic, oe_term;
  logic reg_out_cfg, in_only_cfg;
  logic reg_q, reg_level, comb_level, drive;

  assign mode        = decode_mode(cfg_sync, cfg_arch);
  assign reg_out_cfg = (mode == MODE_REG) && !cfg_io;
  assign in_only_cfg = (mode == MODE_SIMPLE) && cfg_io && !IS_CENTRE;

  pld_term_sum #(.N_TERMS(N_TERMS)) u_sum (
    .pterm     (pterm),
    .sum_all   (sum_all),
    .sum_logic (sum_logic),
    .oe_term   (oe_term)
  );

  // Register stores the inverse of the pin level; pin path inverts back
  pld_state_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (reg_out_cfg),
    .d           (~polarize(sum_all, cfg_pol)),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .q           (reg_q)
  );

  assign reg_level  = ~reg_q;
  assign comb_level = polarize((mode == MODE_SIMPLE) ? sum_all : sum_logic, cfg_pol);

  always_comb begin
    unique case (mode)
      MODE_REG:    drive = cfg_io ? oe_term : ~gl_oe_n;
      MODE_CPLX:   drive = oe_term;
      MODE_SIMPLE: drive = !in_only_cfg;
      default:     drive = 1'b0;
    endcase
  end

  assign pin_oe  = drive;
  assign pin_out = drive & (reg_out_cfg ? reg_level : comb_level);

  pld_fb_route #(.IS_OUTER(IS_OUTER), .IS_CENTRE(IS_CENTRE)) u_fb (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .reg_out_cfg (reg_out_cfg),
    .reg_level   (reg_level),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out),
    .pin_in      (pin_in),
    .neigh_pin   (neigh_pin),
    .fb_out      (fb_out),
    .fb_live     (fb_live)
  );

  AST_RESV_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RESV) |-> (!pin_oe && !fb_live)); // R1
  AST_SIMPLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SIMPLE && !cfg_io) |-> pin_oe); // R6
  AST_CENTRE_NEVER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_CENTRE && mode == MODE_SIMPLE) |-> pin_oe); // R6
  AST_TERM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CPLX) |-> (pin_oe == pterm[N_TERMS-1])); // R4
  AST_REG_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_out_cfg && pin_oe) |-> (fb_out == pin_out)); // R11
endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pterm = 8'h00;
  logic gl_oe_n = 1'b0, cfg_sync = 1'b0, cfg_arch = 1'b1, cfg_pol = 1'b0, cfg_io = 1'b0;
  logic preload_en = 1'b0, preload_val = 1'b0, pin_in = 1'b0, neigh_pin = 1'b0;
  logic pin_out, pin_oe, fb_out, fb_live;
  logic e_out, e_oe, e_fb, e_live;
  logic c_out, c_oe, c_fb, c_live;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pld_out_cell u_dut (.clk, .rst_n, .pterm, .gl_oe_n, .cfg_sync, .cfg_arch, .cfg_pol, .cfg_io,
    .preload_en, .preload_val, .pin_in, .neigh_pin,
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .fb_live(fb_live));
  pld_out_cell #(.IS_OUTER(1'b1)) u_edge (.clk, .rst_n, .pterm, .gl_oe_n, .cfg_sync, .cfg_arch,
    .cfg_pol, .cfg_io, .preload_en, .preload_val, .pin_in, .neigh_pin,
    .pin_out(e_out), .pin_oe(e_oe), .fb_out(e_fb), .fb_live(e_live));
  pld_out_cell #(.IS_CENTRE(1'b1)) u_mid (.clk, .rst_n, .pterm, .gl_oe_n, .cfg_sync, .cfg_arch,
    .cfg_pol, .cfg_io, .preload_en, .preload_val, .pin_in, .neigh_pin,
    .pin_out(c_out), .pin_oe(c_oe), .fb_out(c_fb), .fb_live(c_live));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic set_mode(input logic s, input logic a);
    cfg_sync = s; cfg_arch = a;
  endtask

  task automatic t_reset();
    set_mode(1'b0, 1'b1); cfg_io = 0; gl_oe_n = 0; cfg_pol = 0; settle();
    chk("R8 pin high pol0", pin_out, 1'b1);
    chk("R8 driven", pin_oe, 1'b1);
    cfg_pol = 1; pterm = 8'h00; tick();
    chk("R8 pin high pol1", pin_out, 1'b1);
    chk("R11 reg fb in reset", fb_out, 1'b1);
  endtask

  task automatic t_registered();
    cfg_pol = 1; pterm = 8'h80; tick();
    chk("R3 term7 captured", pin_out, 1'b1);
    pterm = 8'h00; settle();
    chk("R3 no change before edge", pin_out, 1'b1);
    tick();
    chk("R3 zero captured", pin_out, 1'b0);
    cfg_pol = 0; tick();
    chk("R2 active low", pin_out, 1'b1);
    gl_oe_n = 1; settle();
    chk("R3 shared oe off", pin_oe, 1'b0);
    chk("R11 reg fb while off", fb_out, 1'b1);
    gl_oe_n = 0;
  endtask

  task automatic t_preload();
    cfg_pol = 1; pterm = 8'h01;
    preload_en = 1; preload_val = 1; tick();
    chk("R9 preload beats data", pin_out, 1'b0);
    preload_en = 0; pterm = 8'h00; tick();
    chk("R3 after preload", pin_out, 1'b0);
    preload_en = 1; preload_val = 0; tick();
    chk("R9 preload zero beats data", pin_out, 1'b1);
    preload_en = 0;
  endtask

  task automatic t_hold();
    cfg_pol = 1; pterm = 8'h00; tick();
    chk("R3 setup q", pin_out, 1'b0);
    cfg_io = 1; pterm = 8'h01; tick(); tick();
    set_mode(1'b1, 1'b1); tick();
    set_mode(1'b1, 1'b0); cfg_io = 0; tick();
    set_mode(1'b0, 1'b1); cfg_io = 0; settle();
    chk("R10 register held", pin_out, 1'b0);
  endtask

  task automatic t_reg_io();
    set_mode(1'b0, 1'b1); cfg_io = 1; cfg_pol = 1; pterm = 8'h80; settle();
    chk("R4 term7 enables", pin_oe, 1'b1);
    chk("R4 term7 not logic", pin_out, 1'b0);
    pterm = 8'h81; settle();
    chk("R4 logic terms", pin_out, 1'b1);
    chk("R11 fb driven pin", fb_out, 1'b1);
    pterm = 8'h01; pin_in = 1; settle();
    chk("R4 oe off", pin_oe, 1'b0);
    chk("R11 fb ext high", fb_out, 1'b1);
    pin_in = 0; settle();
    chk("R11 fb ext low", fb_out, 1'b0);
  endtask

  task automatic t_complex();
    set_mode(1'b1, 1'b1); cfg_io = 0; cfg_pol = 0; pterm = 8'h82; settle();
    chk("R4 cplx enable", pin_oe, 1'b1);
    chk("R2 cplx active low", pin_out, 1'b0);
    chk("R11 cplx fb", fb_out, 1'b0);
    chk("R5 inner fb live", fb_live, 1'b1);
    chk("R5 outer no fb", e_live, 1'b0);
    pterm = 8'h02; settle();
    chk("R4 cplx disable", pin_oe, 1'b0);
  endtask

  task automatic t_simple();
    set_mode(1'b1, 1'b0); cfg_io = 0; cfg_pol = 1; pterm = 8'h80; settle();
    chk("R6 always on", pin_oe, 1'b1);
    chk("R6 eight terms", pin_out, 1'b1);
    pterm = 8'h00; settle();
    chk("R6 zero", pin_out, 1'b0);
    neigh_pin = 1; pin_in = 0; settle();
    chk("R7 neighbour high", fb_out, 1'b1);
    neigh_pin = 0; pin_in = 1; settle();
    chk("R7 neighbour low", fb_out, 1'b0);
    chk("R7 centre no fb", c_live, 1'b0);
    cfg_io = 1; settle();
    chk("R6 input driver off", pin_oe, 1'b0);
    chk("R6 centre stays output", c_oe, 1'b1);
  endtask

  task automatic t_resv();
    set_mode(1'b0, 1'b0); cfg_io = 0; settle();
    chk("R1 reserved driver off", pin_oe, 1'b0);
    chk("R1 reserved no fb", fb_live, 1'b0);
  endtask

  task automatic t_preload_any();
    set_mode(1'b1, 1'b0); preload_en = 1; preload_val = 1; tick();
    preload_en = 0; set_mode(1'b0, 1'b1); cfg_io = 0; gl_oe_n = 0; settle();
    chk("R9 preload in simple mode", pin_out, 1'b0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    @(negedge clk); rst_n = 1; #1;
    t_registered();
    t_preload();
    t_hold();
    t_reg_io();
    t_complex();
    t_simple();
    t_resv();
    t_preload_any();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule